// File: doc/BRIEF.md
# Coherence Command Throttle with Drop Priority

This block sits between the incoming coherence links and a snoop pipeline that can take only a fixed number of commands per cycle. Every arriving command carries a drop priority: low, medium or high. When more commands arrive in a cycle than the pipeline can take, the block sheds the least important ones. A shed command is answered with a chip-level retry and is never passed on. Commands that fit are forwarded.

On the local issue side, the block lets the command rate run above a fixed worst-case share. Each priority class has its own token bucket. Low-priority commands get the shortest refill period, so they may issue most often. Drop feedback from the fabric lengthens the refill period of the class that was dropped. A programmable quiet interval with no drops shortens it again, always within fixed bounds. A command that is issued again after a drop is raised one priority level before it enters its bucket.

Top module: `coh_drop_throttle`

## Requirements
- R1: Each arriving command with its valid bit set is either forwarded or answered with retry in the same cycle, never both. A link with its valid bit clear gets neither.
- R2: No more than SNOOP_CAP commands are forwarded per cycle. When SNOOP_CAP or fewer commands arrive, all of them are forwarded.
- R3: Priority is encoded as 0 = low, 1 = medium, 2 = high. A forwarded command never has a lower priority than a command shed in the same cycle.
- R4: Among arrivals of equal priority in the same cycle, the lower-numbered link is kept ahead of the higher-numbered one.
- R5: The effective issue priority is the base priority, or base + 1 when the retry flag is set. It saturates at 2 (high).
- R6: An issue request is granted only when the bucket of its effective class holds a token. Each grant takes one token. A bucket holds at most BURST tokens and is full after reset.
- R7: A bucket gains one token every refill-period cycles, counted from reset.
- R8: After reset the low class has the shortest refill period and the high class the longest. Under continuous demand, low-priority issue is therefore granted more often than high-priority issue.
- R9: A drop-feedback pulse for a class lengthens that class's period by PER_STEP, capped at PER_MAX.
- R10: Each run of cfg_quiet consecutive cycles without a drop in a class shortens that class's period by PER_STEP, floored at PER_MIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_valid | input | N_LINKS | Command present on each incoming link |
| arr_prio | input | 2*N_LINKS | Drop priority per link, link i at bits [2i+1:2i] |
| fwd_valid | output | N_LINKS | Command on this link is forwarded to the snoop pipeline |
| retry_rsp | output | N_LINKS | Command on this link is shed and answered with retry |
| iss_req | input | 1 | Local issue request |
| iss_base_prio | input | 2 | Base priority of the issue request |
| iss_retry | input | 1 | Request is a re-issue after a drop |
| iss_grant | output | 1 | Issue permitted this cycle (token taken) |
| iss_prio | output | 2 | Effective priority of the issued command |
| fb_drop | input | 3 | Drop feedback, one bit per class (bit 0 low) |
| cfg_quiet | input | QW | Quiet interval, in cycles, before a period is shortened |

## Verification
The hardest state to reach from the ports is a refill period that has moved: first pushed up to its ceiling, then walked back down to its floor. Only the grant pattern shows the period, and only while the bucket is drained. The stimulus therefore keeps one class requesting on every cycle while it holds drop feedback for long stretches, then releases it with a short quiet interval. A cycle-exact bucket model in the bench follows the period and token count and compares every grant. The arrival side is swept over every mix of valid bits and priorities on three links.

// File: rtl/coh_thr_pkg.sv
// Shared types for the coherence command throttle.
// Priority codes are ordered: a larger code is kept longer.
package coh_thr_pkg;
    typedef enum logic [1:0] {
        PRIO_LOW  = 2'd0,
        PRIO_MED  = 2'd1,
        PRIO_HIGH = 2'd2
    } prio_e;

    localparam int N_CLASSES = 3;

    // Raise a priority one level when the command is a re-issue; saturate at high.
    function automatic logic [1:0] escalate(input logic [1:0] base, input logic retry);
        if (!retry)               return base;
        if (base >= PRIO_HIGH)    return PRIO_HIGH;
        return base + 2'd1;
    endfunction
endpackage

// File: rtl/coh_shed_select.sv
// Picks which arriving commands fit in the snoop capacity.
// A command's rank is the number of valid arrivals that beat it: a higher
// priority, or equal priority on a lower-numbered link. Ranks below CAP are kept.
// Assumes priority codes 0..2; purely combinational.
module coh_shed_select #(
    parameter int N_LINKS = 3,
    parameter int CAP     = 2
) (
    input  logic [N_LINKS-1:0]   valid,
    input  logic [2*N_LINKS-1:0] prio,
    output logic [N_LINKS-1:0]   keep,
    output logic [N_LINKS-1:0]   shed
);
    // Rank each valid arrival against all others and split keep / shed.
    always_comb begin
        keep = '0;
        shed = '0;
        for (int i = 0; i < N_LINKS; i++) begin
            int rank;
            rank = 0;
            for (int j = 0; j < N_LINKS; j++) begin
                if (j != i && valid[j] &&
                    ((prio[2*j +: 2] > prio[2*i +: 2]) ||
                     (prio[2*j +: 2] == prio[2*i +: 2] && j < i)))
                    rank++;
            end
            keep[i] = valid[i] && (rank < CAP);
            shed[i] = valid[i] && (rank >= CAP);
        end
    end
endmodule

// File: rtl/coh_rate_bucket.sv
// Token bucket for one priority class with an adaptive refill period.
// A drop pulse lengthens the period; cfg_quiet drop-free cycles shorten it.
// Assumes consume is raised only while has_token is high and PER_MIN >= 1.
module coh_rate_bucket #(
    parameter int BURST    = 2,
    parameter int PER_INIT = 4,
    parameter int PER_MIN  = 2,
    parameter int PER_MAX  = 32,
    parameter int PER_STEP = 2,
    parameter int QW       = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          consume,
    input  logic          drop,
    input  logic [QW-1:0] cfg_quiet,
    output logic          has_token
);
    localparam int PW = $clog2(PER_MAX + 1);
    localparam int TW = $clog2(BURST + 1);

    logic [TW-1:0] tokens, tokens_n;
    logic [PW-1:0] period, refill_cnt;
    logic [QW-1:0] quiet_cnt;
    logic          refill, quiet_done;

    assign has_token  = (tokens != '0);
    assign refill     = (refill_cnt >= period - PW'(1));
    assign quiet_done = ({1'b0, quiet_cnt} + (QW+1)'(1)) >= {1'b0, cfg_quiet};

    // Next token count: add on refill (saturating), remove on consume.
    always_comb begin
        tokens_n = tokens;
        if (refill && !consume && tokens != TW'(BURST))
            tokens_n = tokens + TW'(1);
        else if (consume && !refill)
            tokens_n = tokens - TW'(1);
    end

    // Token store and refill timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tokens     <= TW'(BURST);
            refill_cnt <= '0;
        end else begin
            tokens     <= tokens_n;
            refill_cnt <= refill ? '0 : refill_cnt + PW'(1);
        end
    end

    // Period adaptation from drop feedback and quiet time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period    <= PW'(PER_INIT);
            quiet_cnt <= '0;
        end else if (drop) begin
            period    <= (period > PW'(PER_MAX - PER_STEP)) ? PW'(PER_MAX) : period + PW'(PER_STEP);
            quiet_cnt <= '0;
        end else if (quiet_done) begin
            period    <= (period < PW'(PER_MIN + PER_STEP)) ? PW'(PER_MIN) : period - PW'(PER_STEP);
            quiet_cnt <= '0;
        end else begin
            quiet_cnt <= quiet_cnt + QW'(1);
        end
    end

    AST_TOKEN_CAP: assert property (@(posedge clk) disable iff (!rst_n) tokens <= TW'(BURST)); // R6
    AST_CONSUME_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !refill |=> tokens == $past(tokens) - TW'(1)); // R6
    AST_PERIOD_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        period >= PW'(PER_MIN) && period <= PW'(PER_MAX)); // R9
    AST_DROP_LENGTHENS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (period == PW'(PER_MAX) || period == $past(period) + PW'(PER_STEP))); // R9
    AST_QUIET_NOT_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        !drop |=> period <= $past(period)); // R10
endmodule

// File: rtl/coh_drop_throttle.sv
// Coherence command throttle: sheds arrivals beyond snoop capacity by drop
// priority, and paces local issue with one adaptive token bucket per class.
// Assumes arrival and issue priority codes stay within 0..2.
module coh_drop_throttle #(
    parameter int N_LINKS   = 3,
    parameter int SNOOP_CAP = 2,
    parameter int BURST     = 2,
    parameter int PER_LO    = 4,
    parameter int PER_MED   = 8,
    parameter int PER_HI    = 16,
    parameter int PER_MIN   = 2,
    parameter int PER_MAX   = 32,
    parameter int PER_STEP  = 2,
    parameter int QW        = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_LINKS-1:0]   arr_valid,
    input  logic [2*N_LINKS-1:0] arr_prio,
    output logic [N_LINKS-1:0]   fwd_valid,
    output logic [N_LINKS-1:0]   retry_rsp,
    input  logic                 iss_req,
    input  logic [1:0]           iss_base_prio,
    input  logic                 iss_retry,
    output logic                 iss_grant,
    output logic [1:0]           iss_prio,
    input  logic [2:0]           fb_drop,
    input  logic [QW-1:0]        cfg_quiet
);
    import coh_thr_pkg::*;

    logic [N_CLASSES-1:0] cls_token;
    logic [N_CLASSES-1:0] cls_take;

    coh_shed_select #(.N_LINKS(N_LINKS), .CAP(SNOOP_CAP)) u_shed (
        .valid (arr_valid),
        .prio  (arr_prio),
        .keep  (fwd_valid),
        .shed  (retry_rsp)
    );

    // Effective priority and grant for the local issuer.
    always_comb begin
        iss_prio  = escalate(iss_base_prio, iss_retry);
        iss_grant = iss_req && cls_token[iss_prio];
        cls_take  = '0;
        cls_take[iss_prio] = iss_grant;
    end

    for (genvar c = 0; c < N_CLASSES; c++) begin : g_cls
        localparam int INIT = (c == 0) ? PER_LO : (c == 1) ? PER_MED : PER_HI;
        coh_rate_bucket #(
            .BURST(BURST), .PER_INIT(INIT), .PER_MIN(PER_MIN),
            .PER_MAX(PER_MAX), .PER_STEP(PER_STEP), .QW(QW)
        ) u_bucket (
            .clk       (clk),
            .rst_n     (rst_n),
            .consume   (cls_take[c]),
            .drop      (fb_drop[c]),
            .cfg_quiet (cfg_quiet),
            .has_token (cls_token[c])
        );
    end

    AST_ACC_DROP_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid & retry_rsp) == '0 && (fwd_valid | retry_rsp) == arr_valid); // R1
    AST_SNOOP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fwd_valid) <= SNOOP_CAP); // R2
    AST_ALL_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(arr_valid) <= SNOOP_CAP |-> retry_rsp == '0); // R2
    for (genvar i = 0; i < N_LINKS; i++) begin : g_ord
        for (genvar j = 0; j < N_LINKS; j++) begin : g_pair
            AST_SHED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                fwd_valid[i] && retry_rsp[j] |-> arr_prio[2*i +: 2] >= arr_prio[2*j +: 2]); // R3
        end
    end
    AST_ESC_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        iss_retry && iss_base_prio <= 2'd2 |-> (iss_prio > iss_base_prio || iss_prio == 2'd2)); // R5
endmodule

// File: tb/coh_drop_throttle_test.sv
// Self-checking bench: arrival sweep over all link mixes, escalation table,
// and a cycle-exact bucket model compared on every issue cycle.
module coh_drop_throttle_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 3, CAP = 2, B = 2;
    localparam int PMIN = 2, PMAX = 32, STEP = 2, QW = 12;

    logic clk = 0, rst_n = 0;
    logic [NL-1:0] arr_valid = '0;
    logic [2*NL-1:0] arr_prio = '0;
    logic [NL-1:0] fwd_valid, retry_rsp;
    logic iss_req = 0, iss_retry = 0, iss_grant;
    logic [1:0] iss_base_prio = '0, iss_prio;
    logic [2:0] fb_drop = '0;
    logic [QW-1:0] cfg_quiet = '1;

    int checks = 0, failures = 0;
    int m_tk[3], m_rc[3], m_per[3], m_q[3];
    int gcount;
    logic [15:0] lfsr = 16'hACE1;

    coh_drop_throttle uut (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_prio(arr_prio),
        .fwd_valid(fwd_valid), .retry_rsp(retry_rsp), .iss_req(iss_req),
        .iss_base_prio(iss_base_prio), .iss_retry(iss_retry), .iss_grant(iss_grant),
        .iss_prio(iss_prio), .fb_drop(fb_drop), .cfg_quiet(cfg_quiet)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_prio(input int base, input bit rt);
        if (!rt) return base;
        return (base >= 2) ? 2 : base + 1;
    endfunction

    task automatic model_reset();
        m_per[0] = 4; m_per[1] = 8; m_per[2] = 16;
        for (int c = 0; c < 3; c++) begin m_tk[c] = B; m_rc[c] = 0; m_q[c] = 0; end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        model_reset();
    endtask

    // One issue cycle: called just after a negedge with inputs set.
    task automatic issue_cycle(input string tag);
        int e, exp_g;
        #1;
        e = eff_prio(iss_base_prio, iss_retry);
        exp_g = (iss_req && m_tk[e] != 0) ? 1 : 0;
        check(iss_grant == exp_g[0], tag, iss_grant, exp_g);
        if (iss_grant) gcount++;
        @(posedge clk);
        for (int c = 0; c < 3; c++) begin
            bit cons, rf;
            cons = exp_g != 0 && e == c;
            rf = m_rc[c] >= m_per[c] - 1;
            if (rf && !cons) m_tk[c] = (m_tk[c] + 1 > B) ? B : m_tk[c] + 1;
            else if (cons && !rf) m_tk[c]--;
            m_rc[c] = rf ? 0 : m_rc[c] + 1;
            if (fb_drop[c]) begin
                m_per[c] = (m_per[c] + STEP > PMAX) ? PMAX : m_per[c] + STEP; m_q[c] = 0;
            end else if (m_q[c] + 1 >= int'(cfg_quiet)) begin
                m_per[c] = (m_per[c] - STEP < PMIN) ? PMIN : m_per[c] - STEP; m_q[c] = 0;
            end else m_q[c]++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int g_lo, g_hi;
        do_reset();
        // Reset state: no arrivals gives no forward and no retry (R1); full bucket grants (R6).
        #1;
        check(fwd_valid == '0 && retry_rsp == '0, "R1 reset idle", fwd_valid, 0);
        iss_req = 1; iss_base_prio = 2'd2; #1;
        check(iss_grant == 1'b1, "R6 full bucket after reset", iss_grant, 1);
        iss_req = 0;

        // Arrival sweep: every mix of valid bit and priority on three links (R1 R2 R3 R4).
        for (int code = 0; code < 64; code++) begin
            logic [NL-1:0] ek, es;
            int pr[NL];
            bit vl[NL];
            for (int i = 0; i < NL; i++) begin
                int d;
                d = (code >> (2*i)) & 3;
                vl[i] = d != 3;
                pr[i] = (d == 3) ? 0 : d;
                arr_valid[i] = vl[i];
                arr_prio[2*i +: 2] = 2'(pr[i]);
            end
            for (int i = 0; i < NL; i++) begin
                int rank;
                rank = 0;
                for (int j = 0; j < NL; j++)
                    if (j != i && vl[j] && (pr[j] > pr[i] || (pr[j] == pr[i] && j < i))) rank++;
                ek[i] = vl[i] && rank < CAP;
                es[i] = vl[i] && rank >= CAP;
            end
            #2;
            check(fwd_valid == ek, "R2 R3 R4 forward set", fwd_valid, ek);
            check(retry_rsp == es, "R1 R3 retry set", retry_rsp, es);
        end
        // Tie on three high-priority arrivals: link 2 is the one shed (R4).
        arr_valid = 3'b111; arr_prio = 6'b10_10_10; #2;
        check(retry_rsp == 3'b100, "R4 equal priority tie", retry_rsp, 4);
        arr_valid = '0;

        // Escalation table (R5).
        for (int b = 0; b < 3; b++)
            for (int r = 0; r < 2; r++) begin
                iss_base_prio = 2'(b); iss_retry = r[0]; #1;
                check(int'(iss_prio) == eff_prio(b, r[0]), "R5 escalation", iss_prio, eff_prio(b, r[0]));
            end
        iss_retry = 0;

        // Rate comparison with periods held fixed (R7 R8).
        cfg_quiet = '1;
        do_reset(); gcount = 0; iss_req = 1; iss_base_prio = 2'd0;
        for (int k = 0; k < 160; k++) issue_cycle("R7 low class pacing");
        g_lo = gcount;
        do_reset(); gcount = 0; iss_base_prio = 2'd2;
        for (int k = 0; k < 160; k++) issue_cycle("R7 high class pacing");
        g_hi = gcount;
        check(g_lo > g_hi, "R8 low issues more than high", g_lo, g_hi + 1);

        // Drive the low class period to its ceiling, then let it relax (R9 R10).
        do_reset(); iss_base_prio = 2'd0; cfg_quiet = QW'(6);
        fb_drop = 3'b001;
        for (int k = 0; k < 60; k++) issue_cycle("R9 drops lengthen period");
        fb_drop = 3'b000;
        for (int k = 0; k < 300; k++) issue_cycle("R10 quiet shortens period");

        // Mixed random traffic with sparse drop feedback (R5 R6 R7 R9 R10).
        do_reset(); cfg_quiet = QW'(24);
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            iss_req = lfsr[0] | lfsr[1];
            iss_base_prio = (lfsr[3:2] == 2'd3) ? 2'd1 : lfsr[3:2];
            iss_retry = lfsr[4];
            fb_drop = {lfsr[15:12] == 4'h0, lfsr[11:8] == 4'h0, lfsr[7:4] == 4'h0};
            issue_cycle("R6 R7 R9 R10 mixed traffic");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule